// File: doc/BRIEF.md
# Posit Exact Dot-Product Accumulator

This block computes dot products of posit-encoded weights and activations without rounding anything along the way. Each cycle it may take one weight and one activation, each `N` bits wide with an `ES`-bit exponent field. It splits both operands into sign, regime, exponent and fraction. It multiplies the two significands exactly. It then turns the product into a two's-complement fixed-point number and adds that number into a wide accumulator (the quire). The accumulator holds every product of a sequence of up to `NOP` terms exactly, so rounding happens only once, in a separate stage that converts the finished sum back to a posit.

The datapath has two stages. The first decodes the operands and multiplies them. The second normalizes the product, places it in fixed-point form and accumulates it. A clear request travels down the pipeline with its operand pair, so a new dot product can start in the cycle right after the previous one ends. A flag on the final pair raises a one-cycle valid strobe at the output once that pair has been added into the quire.

Top module: `pmac_quire_engine`

## Requirements
- R1: While reset is asserted, and right after it is released, `quire` is zero and `outValid` is low.
- R2: An all-zero operand pattern is exactly zero, so a valid pair that contains one leaves `quire` unchanged.
- R3: Each valid pair adds its exact product, scaled by 2^BIAS, into `quire`, where BIAS = 2^(ES+1)·(N-2). For N=8 and ES=1, the pattern 0x40 (one) squared adds 2^24.
- R4: The smallest positive pattern (0x01) times itself adds exactly 1, at bit 0 of `quire`.
- R5: The largest positive pattern (0x7F) times itself adds 2^(2·BIAS), which is 2^48 at N=8 and ES=1, with no loss.
- R6: A negative operand is the two's complement of the matching positive pattern. A product with one negative operand is subtracted from `quire` (for example, 0xFF times 0x01 adds −1).
- R7: `inClear` travels with its operand pair. Two cycles after it is sampled, `quire` holds zero plus that pair's product when `inValid` was high, and plain zero when it was low.
- R8: `outValid` pulses high for one cycle, two clock edges after a pair sampled with `inValid` and `inLast` both high. At that point `quire` includes the final product.
- R9: Cycles with `inValid` and `inClear` both low leave `quire` unchanged, whatever the operand inputs hold.
- R10: `quire` is ceil(log2(NOP)) + 2^(ES+2)·(N-2) + 2 bits wide (54 bits at N=8, ES=1, NOP=16).
- R11: A regime run that reaches the end of the word without a terminating bit is decoded as a regime of value (run length − 1) for ones and −(run length) for zeros, and the exponent and fraction are then zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Marks the operand pair as one term of the dot product |
| inLast | input | 1 | Marks the final term of the dot product |
| inClear | input | 1 | Starts the quire from zero for this pair |
| wgt | input | N | Posit weight |
| act | input | N | Posit activation |
| outValid | output | 1 | One-cycle strobe: the dot product in `quire` is complete |
| quire | output | QW | Exact two's-complement accumulated sum, LSB weight 2^-BIAS |

## Verification
The bench builds the block with N=8, ES=1 and NOP=16. That gives a 54-bit quire with BIAS=24, so every product fits in a 64-bit integer the bench can compute. The extreme scales of minpos squared (bit 0) and maxpos squared (bit 48) can then be checked as exact bit positions. Both ES=1 exponent values, negative two's-complement patterns and the overflow normalization of the significand product all occur in the random 16-term sequences. Those sequences also stay close to the quire's growth headroom. The bench's reference decoder walks each pattern bit by bit, independently of the RTL.

// File: rtl/pmac_pkg.sv
package pmac_pkg;
  // Strobes issued by the sequencing logic to the arithmetic datapath
  typedef struct packed {
    logic capEn;   // capture decoded operand pair into stage 1
    logic accEn;   // stage 1 holds a product to accumulate
    logic clrQ;    // restart the quire from zero at this accumulation
  } pmacStrobe_t;
endpackage

// File: rtl/posit_field_decode.sv
module posit_field_decode #(
  parameter int N  = 8,
  parameter int ES = 1,
  parameter int FW = N - 3 - ES,
  parameter int SW = 6
) (
  input  logic [N-1:0]        word,
  output logic                isZero,
  output logic                sign,
  output logic signed [SW-1:0] scale,
  output logic [FW:0]         mant
);
  logic [N-2:0] mag;
  logic [N-2:0] rem;
  logic [N-2:0] remF;
  logic         runBit;
  logic         stop;
  int           runLen;
  int           regimeVal;
  int           expVal;

  always_comb begin
    isZero = (word == '0);
    sign   = word[N-1];
    mag    = sign ? (N-1)'(-word) : word[N-2:0];
    runBit = mag[N-2];
    runLen = 0;
    stop   = 1'b0;
    for (int i = N - 2; i >= 0; i--) begin
      if (!stop) begin
        if (mag[i] == runBit) runLen = runLen + 1;
        else stop = 1'b1;
      end
    end
    // drop regime run and its terminator, leaving exponent/fraction left-aligned
    rem       = mag << (runLen + 1);
    expVal    = int'(rem >> (N - 1 - ES));
    regimeVal = runBit ? runLen - 1 : -runLen;
    scale     = SW'(regimeVal * (1 << ES) + expVal);
    remF      = rem << ES;
    mant      = (FW+1)'({1'b1, remF} >> (N - 1 - FW));
  end
endmodule

// File: rtl/pmac_ctrl.sv
module pmac_ctrl
  import pmac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inLast,
  input  logic        inClear,
  output pmacStrobe_t strobe,
  output logic        outValid
);
  logic validS1, lastS1, clearS1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validS1  <= 1'b0;
      lastS1   <= 1'b0;
      clearS1  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      validS1  <= inValid;
      lastS1   <= inValid & inLast;
      clearS1  <= inClear;
      outValid <= validS1 & lastS1;
    end
  end

  always_comb begin
    strobe.capEn = inValid;
    strobe.accEn = validS1;
    strobe.clrQ  = clearS1;
  end
endmodule

// File: rtl/pmac_datapath.sv
module pmac_datapath
  import pmac_pkg::*;
#(
  parameter int N    = 8,
  parameter int ES   = 1,
  parameter int FW   = N - 3 - ES,
  parameter int SW   = 6,
  parameter int BIAS = 24,
  parameter int QW   = 54
) (
  input  logic        clk,
  input  logic        rstN,
  input  pmacStrobe_t strobe,
  input  logic [N-1:0] wgt,
  input  logic [N-1:0] act,
  output logic [QW-1:0] quire
);
  localparam int PW = 2 * FW + 2;   // exact significand product width
  localparam int TW = QW + PW;      // headroom for the placement shift

  logic [N-1:0]         opWord  [2];
  logic                 opZero  [2];
  logic                 opSign  [2];
  logic signed [SW-1:0] opScale [2];
  logic [FW:0]          opMant  [2];

  assign opWord[0] = wgt;
  assign opWord[1] = act;

  for (genvar g = 0; g < 2; g++) begin : g_dec
    posit_field_decode #(.N(N), .ES(ES), .FW(FW), .SW(SW)) dec_i (
      .word  (opWord[g]),
      .isZero(opZero[g]),
      .sign  (opSign[g]),
      .scale (opScale[g]),
      .mant  (opMant[g])
    );
  end

  // Stage 1: exact multiply and scale sum
  logic [PW-1:0]        prodS1;
  logic signed [SW:0]   sfS1;
  logic                 negS1;
  logic                 zeroS1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodS1 <= '0;
      sfS1   <= '0;
      negS1  <= 1'b0;
      zeroS1 <= 1'b1;
    end else if (strobe.capEn) begin
      prodS1 <= PW'(opMant[0]) * PW'(opMant[1]);
      sfS1   <= (SW+1)'(opScale[0]) + (SW+1)'(opScale[1]);
      negS1  <= opSign[0] ^ opSign[1];
      zeroS1 <= opZero[0] | opZero[1];
    end
  end

  // Stage 2: normalize, place in fixed point, accumulate
  logic          ovf;
  logic [PW-1:0] normFrac;
  int            sfBiased;
  logic [QW-1:0] fixedMag;
  logic [QW-1:0] fixedTerm;

  always_comb begin
    ovf       = prodS1[PW-1];
    normFrac  = ovf ? prodS1 : (prodS1 << 1);
    sfBiased  = int'(sfS1) + int'(ovf) + BIAS;
    fixedMag  = QW'((TW'(normFrac) << sfBiased) >> (PW - 1));
    fixedTerm = (!strobe.accEn || zeroS1) ? '0 : (negS1 ? -fixedMag : fixedMag);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) quire <= '0;
    else if (strobe.clrQ) quire <= fixedTerm;
    else if (strobe.accEn) quire <= quire + fixedTerm;
  end
endmodule

// File: rtl/pmac_quire_engine.sv
module pmac_quire_engine #(
  parameter int N   = 8,
  parameter int ES  = 1,
  parameter int NOP = 16,
  localparam int FW   = N - 3 - ES,
  localparam int BIAS = (2 ** (ES + 1)) * (N - 2),
  localparam int QW   = $clog2(NOP) + (2 ** (ES + 2)) * (N - 2) + 2,
  localparam int SW   = $clog2(BIAS / 2 + 1) + 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inLast,
  input  logic          inClear,
  input  logic [N-1:0]  wgt,
  input  logic [N-1:0]  act,
  output logic          outValid,
  output logic [QW-1:0] quire
);
  pmac_pkg::pmacStrobe_t strobe;

  pmac_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inLast  (inLast),
    .inClear (inClear),
    .strobe  (strobe),
    .outValid(outValid)
  );

  pmac_datapath #(.N(N), .ES(ES), .FW(FW), .SW(SW), .BIAS(BIAS), .QW(QW)) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wgt   (wgt),
    .act   (act),
    .quire (quire)
  );
endmodule

// File: rtl/pmac_quire_engine_chk.sv
module pmac_quire_engine_chk #(
  parameter int N   = 8,
  parameter int ES  = 1,
  parameter int NOP = 16,
  localparam int QW = $clog2(NOP) + (2 ** (ES + 2)) * (N - 2) + 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic          inLast,
  input logic          inClear,
  input logic [N-1:0]  wgt,
  input logic [N-1:0]  act,
  input logic          outValid,
  input logic [QW-1:0] quire
);
  assert_done_follows_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inLast) |=> ##1 outValid);

  assert_done_needs_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid && inLast, 2));

  assert_idle_holds_quire_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(!inValid && !inClear, 2) |-> $stable(quire));

  assert_clear_alone_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(inClear && !inValid, 2) |-> (quire == '0));

  assert_zero_operand_no_effect_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && !inClear && ((wgt == '0) || (act == '0)), 2) |-> $stable(quire));
endmodule

bind pmac_quire_engine pmac_quire_engine_chk #(.N(N), .ES(ES), .NOP(NOP)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast), .inClear(inClear),
  .wgt(wgt), .act(act), .outValid(outValid), .quire(quire)
);

// File: tb/pmac_quire_engine_tb_top.sv
`timescale 1ns/1ps
module pmac_quire_engine_tb_top;
  localparam int N    = 8;
  localparam int ES   = 1;
  localparam int NOP  = 16;
  localparam int BIAS = (2 ** (ES + 1)) * (N - 2);
  localparam int QW   = $clog2(NOP) + (2 ** (ES + 2)) * (N - 2) + 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN, inValid, inLast, inClear;
  logic [N-1:0]  wgt, act;
  logic          outValid;
  logic [QW-1:0] quire;

  pmac_quire_engine #(.N(N), .ES(ES), .NOP(NOP)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast), .inClear(inClear),
    .wgt(wgt), .act(act), .outValid(outValid), .quire(quire)
  );

  int     checks = 0;
  int     fails  = 0;
  longint expQ   = 0;
  bit     done   = 0;

  // Reference: walk the pattern bit by bit
  function automatic void refDecode(input logic [N-1:0] p, output bit neg,
                                    output int scl, output longint mant, output int nf);
    logic [N-1:0] x;
    int i, run, k, e;
    logic r;
    neg = p[N-1];
    x = neg ? -p : p;
    i = N - 2; r = x[i]; run = 0;
    while (i >= 0 && x[i] == r) begin run++; i--; end
    i--;
    k = r ? run - 1 : -run;
    e = 0;
    for (int j = 0; j < ES; j++) begin
      e = e * 2 + ((i >= 0) ? int'(x[i]) : 0);
      i--;
    end
    mant = 1; nf = 0;
    while (i >= 0) begin mant = mant * 2 + longint'(x[i]); nf++; i--; end
    scl = k * (2 ** ES) + e;
  endfunction

  function automatic longint refTerm(input logic [N-1:0] w, input logic [N-1:0] a);
    bit nw, na; int sw, sa, fw, fa; longint mw, ma, t;
    if (w == '0 || a == '0) return 0;
    refDecode(w, nw, sw, mw, fw);
    refDecode(a, na, sa, ma, fa);
    t = ((mw * ma) << (sw + sa + BIAS)) >> (fw + fa);
    return (nw ^ na) ? -t : t;
  endfunction

  task automatic check(input string req, input logic [63:0] actual, input logic [63:0] expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  function automatic logic [63:0] trunc(input longint v);
    logic [QW-1:0] t;
    t = v[QW-1:0];
    return 64'(t);
  endfunction

  task automatic sendPair(input logic [N-1:0] w, input logic [N-1:0] a,
                          input bit v, input bit last, input bit clr);
    wgt = w; act = a; inValid = v; inLast = last; inClear = clr;
    if (clr) expQ = 0;
    if (v) expQ = expQ + refTerm(w, a);
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0; inClear = 1'b0;
  endtask

  task automatic endCheck(input string req);
    @(negedge clk);
    check({req, " outValid"}, 64'(outValid), 64'd1);
    check({req, " quire"}, 64'(quire), trunc(expQ));
    @(negedge clk);
    check("R8 pulse single", 64'(outValid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pw, pa;
    logic [QW-1:0] held;
    rstN = 1'b0; inValid = 0; inLast = 0; inClear = 0; wgt = '0; act = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 quire in reset", 64'(quire), 64'd0);
    check("R1 outValid in reset", 64'(outValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 quire after reset", 64'(quire), 64'd0);

    check("R10 quire width", 64'($bits(quire)), 64'd54);

    sendPair(8'h01, 8'h01, 1, 1, 1);            // R4 minpos squared
    endCheck("R4");
    check("R4 value one", 64'(quire), 64'd1);

    sendPair(8'h7F, 8'h7F, 1, 1, 1);            // R5 / R11 maxpos squared
    endCheck("R5");
    check("R11 run to end of word", 64'(quire), 64'd1 << 48);

    sendPair(8'h40, 8'h40, 1, 1, 1);            // R3 one times one
    endCheck("R3");
    check("R3 one squared", 64'(quire), 64'd1 << 24);

    sendPair(8'hFF, 8'h01, 1, 1, 1);            // R6 negative product
    endCheck("R6");
    check("R6 minus one", 64'(quire), trunc(-64'sd1));

    sendPair(8'h40, 8'h40, 1, 0, 1);            // R2 zero operand
    sendPair(8'h00, 8'h55, 1, 0, 0);
    sendPair(8'h37, 8'h00, 1, 1, 0);
    endCheck("R2");
    check("R2 zeros ignored", 64'(quire), 64'd1 << 24);

    held = quire;                                // R9 invalid cycles
    sendPair(8'h7F, 8'h7F, 0, 1, 0);
    sendPair(8'h33, 8'hC1, 0, 0, 0);
    repeat (2) @(negedge clk);
    check("R9 invalid ignored", 64'(quire), 64'(held));
    check("R9 no done without valid", 64'(outValid), 64'd0);

    sendPair(8'h55, 8'h55, 0, 0, 1);            // R7 clear alone
    @(negedge clk);
    check("R7 clear alone", 64'(quire), 64'd0);

    sendPair(8'h7F, 8'h01, 1, 0, 0);            // R7 clear with first term, back to back
    sendPair(8'h40, 8'h40, 1, 1, 1);
    endCheck("R7");

    for (int s = 0; s < 14; s++) begin           // R3 / R6 random sequences
      int len;
      len = 1 + int'($urandom % NOP);
      for (int t = 0; t < len; t++) begin
        pw = N'($urandom); pa = N'($urandom);
        if (pw == 8'h80) pw = 8'h81;
        if (pa == 8'h80) pa = 8'h7F;
        if (s == 0) begin pw = 8'h7F; pa = (t % 2 == 0) ? 8'h7F : 8'h81; end
        sendPair(pw, pa, 1, t == len - 1, t == 0);
      end
      endCheck("R3 R6 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule